// File: doc/BRIEF.md
# Receive Frame Buffer with Memory-Mapped Drain

This block takes the receive side of a 10 Gb/s Ethernet MAC and holds whole frames until a DMA engine collects them. The MAC drives a 64-bit beat stream. Each beat carries eight bytes and comes with a valid strobe, first-beat and last-beat markers, and a 3-bit count of unused byte lanes. The block stores each accepted beat in a data FIFO. It counts the beats of the frame in progress and, once the last beat is accepted, pushes the frame's byte length into a separate length FIFO. A frame becomes visible to the reader only at that point.

Frames that do not fit are discarded whole. If the data FIFO cannot take a beat, the write pointer returns to the start of that frame, the rest of the frame is ignored and a drop counter advances. The same happens when the length FIFO is full at the last beat. The input never stalls, so the sink has no ready signal.

A DMA master drains frames through a small read-only slave port. Address 0 is a status word that shows whether a frame is waiting, the length of the frame at the head, and the drop count. Address 1 returns the head data word, and each read of it removes one word.

Top module: `pkt_rx_ctrl`

## Requirements
- R1: After reset the status word reads all zero: no frame waiting, head length 0, drop count 0.
- R2: The length of a stored frame is 8*(B-1) + (8-E) bytes, where B is the number of beats and E is the 3-bit unused-lane count presented on the last beat.
- R3: The status word (read address 0) holds the frame-waiting flag in bit 0, the head frame's byte length in bits 31:16 and the drop count in bits 63:48. All other bits are zero, and the length field is zero when no frame waits.
- R4: Each read of address 1 returns the next head data word in arrival order and removes it. After the last word of a frame is read, the status word shows the next frame, or no frame.
- R5: Beats that arrive outside a frame (with no first-beat marker since the last frame ended) are ignored.
- R6: When the data FIFO (16 words by default) cannot take a beat, the whole frame is discarded, the drop count rises by exactly one, and frames stored earlier remain intact. The frame that follows is accepted normally.
- R7: When the length FIFO (4 entries by default) is full at a frame's last beat, that frame is discarded and the drop count rises by one.
- R8: A read of address 1 while no frame is waiting returns zero and removes nothing.
- R9: A first-beat marker that arrives inside an unfinished frame throws away the partial frame without counting a drop, and starts a new frame with that beat.
- R10: A frame in progress is not visible in the status word. It appears on the clock edge that accepts its last beat.
- R11: A beat that carries both markers is stored as a complete one-beat frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Stream beat valid |
| s_sop | input | 1 | First beat of a frame |
| s_eop | input | 1 | Last beat of a frame |
| s_empty | input | 3 | Unused byte lanes on the last beat |
| s_data | input | 64 | Stream beat data |
| m_addr | input | 1 | Read address: 0 status, 1 data |
| m_read | input | 1 | Read strobe |
| m_readdata | output | 64 | Read data, valid in the same cycle |

## Verification
A wrong internal state shows at the ports in three ways.

- A commit pointer left in the wrong place shows up on the first data read of the next frame, as a word from the wrong frame or a stale word.
- A length entry out of step with the data shows up as a wrong length in the status word, and later as frames that end one or more words early or late.
- A drop that is counted wrongly, or a rollback that is missed, shows in the drop field right after the offending frame. The frame that follows it then reads back with the wrong contents.

Every frame sent is drained and compared word by word at once, so each of these faults surfaces within one frame.

// File: rtl/pkt_rx_ctrl.sv
module pkt_rx_ctrl #(
  parameter int DATA_AW = 4,
  parameter int LEN_AW  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_valid,
  input  logic        s_sop,
  input  logic        s_eop,
  input  logic [2:0]  s_empty,
  input  logic [63:0] s_data,
  input  logic        m_addr,
  input  logic        m_read,
  output logic [63:0] m_readdata
);
  localparam int DEPTH  = 1 << DATA_AW;
  localparam int LDEPTH = 1 << LEN_AW;
  localparam int PW     = DATA_AW + 1;
  localparam int LPW    = LEN_AW + 1;

  logic [63:0] mem  [DEPTH];
  logic [15:0] lmem [LDEPTH];
  logic [PW-1:0]  wr_ptr, wr_base, rd_ptr, beat_cnt;
  logic [LPW-1:0] lw_ptr, lr_ptr;
  logic           in_frame, dropping;
  logic [15:0]    drop_cnt, head_rd;

  wire          avail      = lw_ptr != lr_ptr;
  wire          lfull      = (lw_ptr - lr_ptr) == LPW'(LDEPTH);
  wire [15:0]   head_len   = avail ? lmem[lr_ptr[LEN_AW-1:0]] : 16'h0;
  wire [15:0]   head_beats = (head_len + 16'd7) >> 3;
  wire          pop        = m_read && m_addr && avail;
  wire [PW-1:0] start      = s_sop ? wr_base : wr_ptr;
  wire          space      = (start - rd_ptr) != PW'(DEPTH);
  wire          take       = s_valid && (s_sop || (in_frame && !dropping));
  wire          wr_en      = take && space;
  wire          commit     = wr_en && s_eop && !lfull;
  wire          drop       = (take && !space) || (wr_en && s_eop && lfull);
  wire [PW-1:0] prior      = s_sop ? '0 : beat_cnt;
  wire [15:0]   new_len    = 16'({prior, 3'b000}) + 16'(4'd8 - {1'b0, s_empty});

  assign m_readdata = m_addr ? (avail ? mem[rd_ptr[DATA_AW-1:0]] : 64'h0)
                             : {drop_cnt, 16'h0, head_len, 15'h0, avail};

  always_ff @(posedge clk) begin
    if (wr_en) mem[start[DATA_AW-1:0]] <= s_data;
    if (commit) lmem[lw_ptr[LEN_AW-1:0]] <= new_len;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0; wr_base <= '0; rd_ptr <= '0; beat_cnt <= '0;
      lw_ptr <= '0; lr_ptr <= '0; in_frame <= 1'b0; dropping <= 1'b0;
      drop_cnt <= '0; head_rd <= '0;
    end else begin
      if (pop) begin
        rd_ptr <= rd_ptr + 1'b1;
        if (head_rd + 16'd1 == head_beats) begin
          head_rd <= '0;
          lr_ptr  <= lr_ptr + 1'b1;
        end else begin
          head_rd <= head_rd + 16'd1;
        end
      end
      if (drop) begin
        drop_cnt <= drop_cnt + 16'd1;
        wr_ptr   <= wr_base;
      end
      if (commit) begin
        wr_ptr  <= start + 1'b1;
        wr_base <= start + 1'b1;
        lw_ptr  <= lw_ptr + 1'b1;
      end else if (wr_en && !s_eop) begin
        wr_ptr <= start + 1'b1;
      end
      if (wr_en && !s_eop) beat_cnt <= prior + 1'b1;
      if (s_valid && (s_sop || in_frame)) begin
        in_frame <= !s_eop;
        dropping <= !s_eop && (drop || (dropping && !s_sop));
      end
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr - rd_ptr) <= PW'(DEPTH));
  assert_len_fifo_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lw_ptr - lr_ptr) <= LPW'(LDEPTH));
  assert_head_len_sane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    avail |-> (head_len != 16'h0 && head_len <= 16'(8 * DEPTH)));
  assert_idle_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_read && m_addr && !avail) |=> rd_ptr == $past(rd_ptr));
  assert_drop_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (drop_cnt == $past(drop_cnt) || drop_cnt == $past(drop_cnt) + 16'd1));
  assert_commit_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_eop) |=> lw_ptr == $past(lw_ptr));
endmodule

// File: tb/pkt_rx_ctrl_tb.sv
`timescale 1ns/1ps
module pkt_rx_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic s_valid = 0, s_sop = 0, s_eop = 0, m_addr = 0, m_read = 0;
  logic [2:0] s_empty = 0;
  logic [63:0] s_data = 0, m_readdata;
  int checks = 0, fails = 0, drops = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pkt_rx_ctrl dut_i (.clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_sop(s_sop),
    .s_eop(s_eop), .s_empty(s_empty), .s_data(s_data), .m_addr(m_addr),
    .m_read(m_read), .m_readdata(m_readdata));

  function automatic logic [63:0] word(int f, int b);
    return {16'hC0DE, 16'(f), 16'h5A00, 16'(b)};
  endfunction

  function automatic logic [63:0] stat(int len);
    return {16'(drops), 16'h0, 16'(len), 15'h0, len != 0};
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic beat(bit sop, bit eop, logic [2:0] e, logic [63:0] d);
    @(negedge clk);
    s_valid = 1; s_sop = sop; s_eop = eop; s_empty = e; s_data = d;
    @(posedge clk); #1 s_valid = 0; s_sop = 0; s_eop = 0;
  endtask

  task automatic send(int f, int n, logic [2:0] e);
    for (int b = 0; b < n; b++) beat(b == 0, b == n - 1, (b == n - 1) ? e : 3'd0, word(f, b));
  endtask

  task automatic peek(output logic [63:0] v);
    @(negedge clk); m_addr = 0; m_read = 0; #1 v = m_readdata;
  endtask

  task automatic rd(output logic [63:0] v);
    @(negedge clk); m_addr = 1; m_read = 1; #1 v = m_readdata;
    @(posedge clk); #1 m_read = 0; m_addr = 0;
  endtask

  task automatic drain(string tag, int f, int n, logic [2:0] e);
    logic [63:0] v;
    peek(v); chk({tag, " status"}, v, stat(8 * (n - 1) + 8 - e));
    for (int b = 0; b < n; b++) begin rd(v); chk({tag, " data"}, v, word(f, b)); end
  endtask

  initial begin
    logic [63:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    peek(v); chk("R1 reset status", v, 64'h0);

    for (int n = 1; n <= 4; n++)
      for (int e = 0; e < 8; e++) begin
        send(n * 8 + e, n, 3'(e));
        drain((n == 1) ? "R11/R2/R3/R4" : "R2/R3/R4", n * 8 + e, n, 3'(e));
        peek(v); chk("R4 head advance", v, stat(0));
      end

    beat(0, 0, 0, 64'h1); beat(0, 1, 3'd2, 64'h2);
    peek(v); chk("R5 stray beats", v, stat(0));

    rd(v); chk("R8 idle read", v, 64'h0);
    send(100, 2, 3'd1); drain("R8 no pop", 100, 2, 3'd1);

    send(101, 3, 0); peek(v); chk("R10 frame visible", v, stat(24));
    beat(1, 0, 0, word(102, 0)); beat(0, 0, 0, word(102, 1));
    peek(v); chk("R10 partial hidden", v, stat(24));
    beat(0, 1, 0, word(102, 2));
    drain("R10 first", 101, 3, 0); drain("R10 second", 102, 3, 0);

    beat(1, 0, 0, word(103, 0)); beat(0, 0, 0, word(103, 1));
    beat(1, 1, 3'd3, word(104, 0));
    drain("R9 abort", 104, 1, 3'd3);

    send(105, 17, 0); drops++;
    peek(v); chk("R6 oversize drop", v, stat(0));
    send(106, 2, 0); drain("R6 after drop", 106, 2, 0);

    for (int f = 0; f < 3; f++) send(110 + f, 4, 3'(f));
    send(113, 5, 0); drops++;
    for (int f = 0; f < 3; f++) drain("R6 prior intact", 110 + f, 4, 3'(f));
    peek(v); chk("R6 empty after", v, stat(0));

    for (int f = 0; f < 5; f++) send(120 + f, 1, 3'd4);
    drops++;
    for (int f = 0; f < 4; f++) drain("R7 len full", 120 + f, 1, 3'd4);
    peek(v); chk("R7 fifth dropped", v, stat(0));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog got=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule